// File: doc/BRIEF.md
# Processor bus cycle sequencer

This block turns a per-machine-cycle request from an 8-bit CPU core into the timed, active-low strobes of a classic multiplexed-control external bus. It runs on a clock at twice the T-state rate, so one clock period is half a T-state: the first half follows the rising T-clock edge and the second half follows the falling one. This lets every strobe edge fall on the T-state boundary or the mid-T-state point where the bus expects it. The sequencer supports five cycle kinds: opcode fetch with a trailing memory-refresh phase, memory read, memory write, I/O read and I/O write.

The core offers a request (kind, address, write data) and the block accepts it when the bus is idle or when the current cycle is in its final half-T-state. Back-to-back cycles therefore run with no dead clock. Read data is taken from a separate input bus and returned with a one-clock valid pulse. Write data goes out on a separate output bus and stays there after the cycle ends, until the next write replaces it. An external wait line and a memory-side busy line both stretch a cycle in whole T-states. The refresh address combines a 7-bit counter with upper bits supplied by the core.

Top module: `zbs_bus_seq`

## Requirements
- R1: While reset is asserted and right after it is released, every strobe is high, ready is high, done and rdata_valid are low, the output data bus is zero and the refresh counter is zero.
- R2: An opcode fetch without stall lasts 4 T-states (8 clocks). fetch_n, mem_sel_n and rd_n are low from the start of T1 through the first half of T3 (2.5 T-states). The input bus is captured at the end of that window.
- R3: In a fetch, refresh_n is low from the second half of T3 through the end of T4, and mem_sel_n is low again during the first half of T4 only. In that phase the address bus carries {refresh_hi, counter[6:0]}. The 7-bit counter increments after each fetch and wraps from 127 to 0, so address bit 7 always comes from refresh_hi and the counter never changes it.
- R4: A memory read without stall lasts 3 T-states. mem_sel_n and rd_n are low from mid-T1 through the first half of T3 (2 T-states). The input bus is captured at the end of the first half of T3, and rdata_valid is high for the next clock.
- R5: A memory write without stall lasts 3 T-states. mem_sel_n is low from mid-T1 through the first half of T3, wr_n is low from mid-T2 through the first half of T3, and the output bus shows the new data from the start of T1. rd_n and wr_n are never low together.
- R6: An I/O cycle lasts 4 T-states, because one wait state always follows T2. io_sel_n and either rd_n (read) or wr_n (write) are low from the start of T2 through the first half of T3. Read data is captured as in R4.
- R7: The output data bus keeps the last written value through every later non-write cycle and through idle time.
- R8: A stall (wait_n low or mem_busy high) is sampled at the end of the first half of T2 for fetch and memory cycles, and at the end of the first half of each wait state for every cycle kind. Each stalled sample adds one full wait state before T3. A stall at any other half-T-state has no effect.
- R9: done is high during the final half-T-state of each cycle, and ready is high when idle or during that half. A request accepted there starts T1 on the next clock. Kind codes: 0 fetch, 1 memory read, 2 memory write, 3 I/O read, 4 I/O write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the T-state rate |
| rst_n | input | 1 | Active-low reset |
| req_valid_i | input | 1 | Core offers a machine-cycle request |
| req_kind_i | input | 3 | Cycle kind code (R9); 5 to 7 reserved |
| req_addr_i | input | AW | Cycle address |
| req_wdata_i | input | DW | Write data for write kinds |
| req_ready_o | output | 1 | Request accepted on this clock if valid |
| refresh_hi_i | input | AW-RFW | Upper bits of the refresh address |
| wait_n_i | input | 1 | External wait, low stretches |
| mem_busy_i | input | 1 | Memory-side busy, high stretches |
| din_i | input | DW | Input data bus |
| addr_o | output | AW | Address bus |
| dout_o | output | DW | Output data bus, held between writes |
| mem_sel_n_o | output | 1 | Memory request strobe |
| io_sel_n_o | output | 1 | I/O request strobe |
| rd_n_o | output | 1 | Read strobe |
| wr_n_o | output | 1 | Write strobe |
| fetch_n_o | output | 1 | Opcode fetch marker |
| refresh_n_o | output | 1 | Refresh phase marker |
| done_o | output | 1 | Final half-T-state of the cycle |
| rdata_o | output | DW | Captured read data |
| rdata_valid_o | output | 1 | rdata_o is fresh this clock |

## Verification
The end of one cycle and the acceptance of the next fall in the same clock. Every request in the sweep is raised during the final half-T-state of the cycle before it, so the bench checks that done and ready are high there and that the new cycle's T1 strobes appear on the very next clock. A second overlap is a stall arriving while a strobe is changing. In a noise mode the bench holds the stall inputs active at every half-T-state that is not a sampling point, including the edges where the strobes change. It then judges each half-T-state of the cycle against a timeline computed from the kind and the intended number of wait states.

// File: rtl/zbs_pkg.sv
package zbs_pkg;

   typedef enum logic [2:0] {
      K_FETCH = 3'd0,
      K_MRD   = 3'd1,
      K_MWR   = 3'd2,
      K_IORD  = 3'd3,
      K_IOWR  = 3'd4
   } kind_e;

   typedef enum logic [2:0] {
      TS_T1 = 3'd0,
      TS_T2 = 3'd1,
      TS_TW = 3'd2,
      TS_T3 = 3'd3,
      TS_T4 = 3'd4
   } tst_e;

   // active-high internal strobe set
   typedef struct packed {
      logic m1;
      logic mreq;
      logic iorq;
      logic rd;
      logic wr;
      logic rfsh;
   } strb_t;

   function automatic logic kind_is_io(input kind_e k);
      return (k == K_IORD) || (k == K_IOWR);
   endfunction

   function automatic logic kind_is_write(input kind_e k);
      return (k == K_MWR) || (k == K_IOWR);
   endfunction

endpackage

// File: rtl/zbs_phase.sv
module zbs_phase
   import zbs_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  start_i,
   input  kind_e kind_i,
   input  logic  stall_i,
   output logic  act_o,
   output kind_e kind_o,
   output tst_e  tst_o,
   output logic  half_o,
   output logic  last_o,
   output logic  capture_o,
   output logic  refr_step_o
);

   logic  act_q;
   logic  half_q;
   logic  ext_q;
   tst_e  tst_q;
   kind_e kind_q;
   logic  io_w;
   logic  samp_w;

   assign io_w   = kind_is_io(kind_q);
   assign last_o = act_q && half_q &&
                   ((tst_q == TS_T4) || ((tst_q == TS_T3) && (kind_q != K_FETCH)));
   // stall sampling point: first half of T2 (not I/O) or of any wait state
   assign samp_w = ((tst_q == TS_T2) && !io_w) || (tst_q == TS_TW);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         half_q <= 1'b0;
         ext_q  <= 1'b0;
         tst_q  <= TS_T1;
         kind_q <= K_FETCH;
      end else if (!act_q || last_o) begin
         half_q <= 1'b0;
         tst_q  <= TS_T1;
         ext_q  <= 1'b0;
         act_q  <= start_i;
         if (start_i) kind_q <= kind_i;
      end else if (!half_q) begin
         half_q <= 1'b1;
         if (samp_w) ext_q <= stall_i;
      end else begin
         half_q <= 1'b0;
         unique case (tst_q)
            TS_T1:   tst_q <= TS_T2;
            TS_T2:   tst_q <= (io_w || ext_q) ? TS_TW : TS_T3;
            TS_TW:   tst_q <= ext_q ? TS_TW : TS_T3;
            TS_T3:   tst_q <= TS_T4;
            default: tst_q <= TS_T1;
         endcase
      end
   end

   assign act_o       = act_q;
   assign kind_o      = kind_q;
   assign tst_o       = tst_q;
   assign half_o      = half_q;
   assign capture_o   = act_q && !half_q && (tst_q == TS_T3) && !kind_is_write(kind_q);
   assign refr_step_o = act_q && half_q && (tst_q == TS_T4);

   assert_wait_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q && half_q && (tst_q == TS_TW) && ext_q) |=> (tst_q == TS_TW));

   assert_io_forced_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q && io_w && half_q && (tst_q == TS_T2)) |=> (tst_q == TS_TW));

endmodule

// File: rtl/zbs_strobe.sv
module zbs_strobe
   import zbs_pkg::*;
(
   input  logic  act_i,
   input  kind_e kind_i,
   input  tst_e  tst_i,
   input  logic  half_i,
   output strb_t strb_o
);

   logic mid_w, t1b_w, t3a_w, t3b_w, t4a_w, t2b_w;

   assign mid_w = (tst_i == TS_T2) || (tst_i == TS_TW);
   assign t1b_w = (tst_i == TS_T1) && half_i;
   assign t2b_w = (tst_i == TS_T2) && half_i;
   assign t3a_w = (tst_i == TS_T3) && !half_i;
   assign t3b_w = (tst_i == TS_T3) && half_i;
   assign t4a_w = (tst_i == TS_T4) && !half_i;

   always_comb begin
      strb_o = '0;
      if (act_i) begin
         unique case (kind_i)
            K_FETCH: begin
               strb_o.m1   = (tst_i == TS_T1) || mid_w || t3a_w;
               strb_o.rd   = strb_o.m1;
               strb_o.mreq = strb_o.m1 || t4a_w;
               strb_o.rfsh = t3b_w || (tst_i == TS_T4);
            end
            K_MRD: begin
               strb_o.mreq = t1b_w || mid_w || t3a_w;
               strb_o.rd   = strb_o.mreq;
            end
            K_MWR: begin
               strb_o.mreq = t1b_w || mid_w || t3a_w;
               strb_o.wr   = t2b_w || (tst_i == TS_TW) || t3a_w;
            end
            K_IORD: begin
               strb_o.iorq = mid_w || t3a_w;
               strb_o.rd   = strb_o.iorq;
            end
            K_IOWR: begin
               strb_o.iorq = mid_w || t3a_w;
               strb_o.wr   = strb_o.iorq;
            end
            default: strb_o = '0;
         endcase
      end
   end

endmodule

// File: rtl/zbs_refresh.sv
module zbs_refresh #(
   parameter int RFW = 7
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           step_i,
   output logic [RFW-1:0] cnt_o
);

   logic [RFW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (step_i) cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o = cnt_q;

   assert_refresh_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != $past(cnt_q)) |-> $past(step_i));

endmodule

// File: rtl/zbs_bus_seq.sv
module zbs_bus_seq
   import zbs_pkg::*;
#(
   parameter int AW  = 16,
   parameter int DW  = 8,
   parameter int RFW = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid_i,
   input  logic [2:0]        req_kind_i,
   input  logic [AW-1:0]     req_addr_i,
   input  logic [DW-1:0]     req_wdata_i,
   output logic              req_ready_o,
   input  logic [AW-RFW-1:0] refresh_hi_i,
   input  logic              wait_n_i,
   input  logic              mem_busy_i,
   input  logic [DW-1:0]     din_i,
   output logic [AW-1:0]     addr_o,
   output logic [DW-1:0]     dout_o,
   output logic              mem_sel_n_o,
   output logic              io_sel_n_o,
   output logic              rd_n_o,
   output logic              wr_n_o,
   output logic              fetch_n_o,
   output logic              refresh_n_o,
   output logic              done_o,
   output logic [DW-1:0]     rdata_o,
   output logic              rdata_valid_o
);

   localparam int HIW = AW - RFW;

   generate
      if (RFW < 1 || RFW >= AW) begin : g_bad_rfw
         $error("zbs_bus_seq: RFW must lie in 1..AW-1");
      end
      if (DW < 1) begin : g_bad_dw
         $error("zbs_bus_seq: DW must be positive");
      end
   endgenerate

   logic           act_w, half_w, last_w, cap_w, step_w, start_w, stall_w;
   kind_e          kind_w;
   tst_e           tst_w;
   strb_t          strb_w;
   logic [RFW-1:0] rcnt_w;
   logic [AW-1:0]  addr_q;
   logic [DW-1:0]  dout_q, rdata_q;
   logic           rvalid_q;
   kind_e          req_kind_w;

   assign req_kind_w  = kind_e'(req_kind_i);
   assign stall_w     = !wait_n_i || mem_busy_i;
   assign req_ready_o = !act_w || last_w;
   assign start_w     = req_valid_i && req_ready_o;

   zbs_phase u_phase (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_w),
      .kind_i      (req_kind_w),
      .stall_i     (stall_w),
      .act_o       (act_w),
      .kind_o      (kind_w),
      .tst_o       (tst_w),
      .half_o      (half_w),
      .last_o      (last_w),
      .capture_o   (cap_w),
      .refr_step_o (step_w)
   );

   zbs_strobe u_strobe (
      .act_i  (act_w),
      .kind_i (kind_w),
      .tst_i  (tst_w),
      .half_i (half_w),
      .strb_o (strb_w)
   );

   zbs_refresh #(.RFW(RFW)) u_refresh (
      .clk    (clk),
      .rst_n  (rst_n),
      .step_i (step_w),
      .cnt_o  (rcnt_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q   <= '0;
         dout_q   <= '0;
         rdata_q  <= '0;
         rvalid_q <= 1'b0;
      end else begin
         if (start_w) begin
            addr_q <= req_addr_i;
            if (kind_is_write(req_kind_w)) dout_q <= req_wdata_i;
         end
         rvalid_q <= cap_w;
         if (cap_w) rdata_q <= din_i;
      end
   end

   logic [AW-1:0] raddr_w;
   assign raddr_w = {refresh_hi_i[HIW-1:0], rcnt_w};

   assign addr_o        = strb_w.rfsh ? raddr_w : addr_q;
   assign dout_o        = dout_q;
   assign mem_sel_n_o   = !strb_w.mreq;
   assign io_sel_n_o    = !strb_w.iorq;
   assign rd_n_o        = !strb_w.rd;
   assign wr_n_o        = !strb_w.wr;
   assign fetch_n_o     = !strb_w.m1;
   assign refresh_n_o   = !strb_w.rfsh;
   assign done_o        = last_w;
   assign rdata_o       = rdata_q;
   assign rdata_valid_o = rvalid_q;

   assert_rd_wr_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n_o && !wr_n_o));

   assert_space_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_sel_n_o && !io_sel_n_o));

   assert_refresh_no_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !refresh_n_o |-> (rd_n_o && fetch_n_o));

   assert_rvalid_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rdata_valid_o |-> !$past(rd_n_o));

   assert_dout_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n_o |-> $stable(dout_o));

endmodule

// File: tb/zbs_bus_seq_tb.sv
module zbs_bus_seq_tb_top;

   localparam int AW  = 16;
   localparam int DW  = 8;
   localparam int RFW = 7;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic [2:0]        req_kind = '0;
   logic [AW-1:0]     req_addr = '0;
   logic [DW-1:0]     req_wdata = '0;
   logic              req_ready;
   logic [AW-RFW-1:0] refresh_hi = '0;
   logic              wait_n = 1'b1;
   logic              mem_busy = 1'b0;
   logic [DW-1:0]     din = '0;
   logic [AW-1:0]     addr;
   logic [DW-1:0]     dout;
   logic              mem_sel_n, io_sel_n, rd_n, wr_n, fetch_n, refresh_n, done;
   logic [DW-1:0]     rdata;
   logic              rvalid;

   int n_chk = 0;
   int n_bad = 0;
   int fetch_cnt = 0;
   logic [DW-1:0] last_wd = '0;

   always #2.5 clk = ~clk;

   zbs_bus_seq #(.AW(AW), .DW(DW), .RFW(RFW)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_kind_i(req_kind),
      .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_ready_o(req_ready),
      .refresh_hi_i(refresh_hi), .wait_n_i(wait_n), .mem_busy_i(mem_busy),
      .din_i(din), .addr_o(addr), .dout_o(dout), .mem_sel_n_o(mem_sel_n),
      .io_sel_n_o(io_sel_n), .rd_n_o(rd_n), .wr_n_o(wr_n), .fetch_n_o(fetch_n),
      .refresh_n_o(refresh_n), .done_o(done), .rdata_o(rdata),
      .rdata_valid_o(rvalid)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   // one machine cycle, entered and left at a negedge; nw = extra wait states
   task automatic run_cycle(input int kind, input int nw, input bit use_busy,
                            input bit noise, input logic [AW-1:0] a,
                            input logic [DW-1:0] wd, input logic [DW-1:0] rp);
      int t3a, len, base;
      bit is_wr, is_rd;
      t3a   = ((kind >= 3) ? 6 : 4) + 2 * nw;
      len   = (kind == 0) ? t3a + 4 : t3a + 2;
      base  = (kind >= 3) ? 4 : 2;
      is_wr = (kind == 2) || (kind == 4);
      is_rd = !is_wr;
      chk(req_ready == 1'b1, "R9 ready before request", 32'(req_ready), 32'd1);
      req_valid = 1'b1;
      req_kind  = 3'(kind);
      req_addr  = a;
      req_wdata = wd;
      din       = rp;
      for (int i = 0; i < len; i++) begin
         logic [5:0] got, exp;
         logic [AW-1:0] ea;
         bit m1, mq, iq, rdx, wrx, rf, sp, st;
         @(negedge clk);
         if (i == 0) req_valid = 1'b0;
         m1 = 0; mq = 0; iq = 0; rdx = 0; wrx = 0; rf = 0;
         case (kind)
            0: begin m1 = (i <= t3a); rdx = m1; mq = m1 || (i == t3a + 2); rf = (i > t3a); end
            1: begin mq = (i >= 1) && (i <= t3a); rdx = mq; end
            2: begin mq = (i >= 1) && (i <= t3a); wrx = (i >= 3) && (i <= t3a); end
            3: begin iq = (i >= 2) && (i <= t3a); rdx = iq; end
            default: begin iq = (i >= 2) && (i <= t3a); wrx = iq; end
         endcase
         got = {fetch_n, mem_sel_n, io_sel_n, rd_n, wr_n, refresh_n};
         exp = ~{m1, mq, iq, rdx, wrx, rf};
         case (kind)
            0: chk(got == exp, "R2/R3 fetch strobes", 32'(got), 32'(exp));
            1: chk(got == exp, "R4 memory read strobes", 32'(got), 32'(exp));
            2: chk(got == exp, "R5 memory write strobes", 32'(got), 32'(exp));
            default: chk(got == exp, "R6 io strobes", 32'(got), 32'(exp));
         endcase
         ea = (kind == 0 && i > t3a) ? {refresh_hi, 7'(fetch_cnt)} : a;
         chk(addr == ea, "R3 address bus", 32'(addr), 32'(ea));
         chk(done == (i == len - 1), "R9 done in final half", 32'(done),
             32'(i == len - 1));
         if (is_wr) chk(dout == wd, "R5 output data from T1", 32'(dout), 32'(wd));
         else       chk(dout == last_wd, "R7 output data held", 32'(dout), 32'(last_wd));
         chk(rvalid == (is_rd && i == t3a + 1), "R4 rdata_valid timing",
             32'(rvalid), 32'(is_rd && i == t3a + 1));
         if (is_rd && i == t3a + 1)
            chk(rdata == rp, "R2/R4 captured data", 32'(rdata), 32'(rp));
         // stall drive for this half (R8)
         sp = (i >= base) && (((i - base) % 2) == 0) && (((i - base) / 2) <= nw);
         st = sp ? (((i - base) / 2) < nw) : noise;
         if (i == len - 1) st = 1'b0;
         if (use_busy) begin mem_busy = st; wait_n = 1'b1; end
         else          begin wait_n = !st; mem_busy = 1'b0; end
      end
      if (kind == 0) fetch_cnt++;
      if (is_wr) last_wd = wd;
   endtask

   initial begin
      #400000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk({fetch_n, mem_sel_n, io_sel_n, rd_n, wr_n, refresh_n} == 6'h3f,
          "R1 strobes in reset", 32'({fetch_n, mem_sel_n, io_sel_n, rd_n, wr_n, refresh_n}), 32'h3f);
      rst_n = 1'b1;
      @(negedge clk);
      chk({fetch_n, mem_sel_n, io_sel_n, rd_n, wr_n, refresh_n} == 6'h3f,
          "R1 strobes after reset", 32'({fetch_n, mem_sel_n, io_sel_n, rd_n, wr_n, refresh_n}), 32'h3f);
      chk(req_ready && !done && !rvalid, "R1 handshake after reset",
          32'({req_ready, done, rvalid}), 32'h4);
      chk(dout == '0, "R1 output data after reset", 32'(dout), 32'd0);
      // sweep kinds x waits x stall source x noise, back-to-back
      for (int k = 0; k < 5; k++) begin
         for (int nw = 0; nw < 4; nw++)
            for (int b = 0; b < 2; b++)
               for (int nz = 0; nz < 2; nz++) begin
                  refresh_hi = 9'(9'h0a5 + k * 7 + nw);
                  run_cycle(k, nw, b[0], nz[0], 16'(16'h1234 + k * 301 + nw * 17 + b * 5 + nz),
                            8'(8'h3c + k * 11 + nw * 3 + b + nz * 2),
                            8'(8'hc1 ^ (k * 29 + nw * 7 + b * 3 + nz)));
               end
         // idle gap between kinds
         for (int g = 0; g < 3; g++) begin
            @(negedge clk);
            chk({mem_sel_n, io_sel_n, rd_n, wr_n} == 4'hf && req_ready && !done,
                "R9 idle between cycles", 32'({mem_sel_n, io_sel_n, rd_n, wr_n, req_ready, done}),
                32'h3e);
            chk(dout == last_wd, "R7 output held while idle", 32'(dout), 32'(last_wd));
         end
      end
      // refresh counter wrap with bit 7 supplied from outside (R3)
      refresh_hi = 9'h155;
      for (int f = 0; f < 140; f++)
         run_cycle(0, 0, 1'b0, f[0], 16'(16'h8000 + f), 8'h00, 8'(f * 13));
      refresh_hi = 9'h0aa;
      for (int f = 0; f < 4; f++)
         run_cycle(0, f % 2, 1'b1, 1'b1, 16'(16'h4000 + f), 8'h00, 8'(f + 1));
      @(negedge clk);
      summary();
      $finish;
   end

endmodule